// File: doc/BRIEF.md
# Multiple-Register Transfer Address Sequencer

This block steps through one load-multiple or store-multiple operation. A command carries a register mask (one bit per register), a base address and four mode bits: offset-before-access, count-upward, update-base and load-direction. The sequencer issues one word-wide memory request per accepted handshake. Each request carries the word address, the register index and a read/write flag. After the last request it raises a one-cycle completion pulse, together with the new base value when update-base is set.

Registers always move in ascending index order to ascending addresses, including in the downward modes. To make that possible, the first address is computed up front from the number of set mask bits. The four modes cover block copies in both directions and stack push/pop. A push onto a full-descending stack is downward with the offset applied before each access. The matching pop is upward with the offset applied after each access.

Top module: `blk_xfer_seq`

## Requirements
- R1: After reset the sequencer is idle: `cmd_ready`=1, and `req_valid`, `done`, `err` and `wb_valid` are 0.
- R2: With n set mask bits, exactly n requests are issued. They carry the set bit indices in ascending order, and the k-th request (k from 0) has address first+4k, modulo 2^AW.
- R3: Upward with offset after access (`cmd_up`=1, `cmd_pre`=0): the first address is the base.
- R4: Upward with offset before access (`cmd_up`=1, `cmd_pre`=1): the first address is base+4.
- R5: Downward with offset after access (`cmd_up`=0, `cmd_pre`=0): the highest address is the base, so the first address is base−4n+4.
- R6: Downward with offset before access (`cmd_up`=0, `cmd_pre`=1): the highest address is base−4, so the first address is base−4n.
- R7: With `cmd_wback`=1 and a non-empty mask, `wb_valid` is 1 in the `done` cycle and `wb_addr` is base+4n when upward or base−4n when downward. With `cmd_wback`=0, `wb_valid` stays 0.
- R8: `req_load` equals the `cmd_load` bit of the command (1 = read from memory, 0 = write) on every request.
- R9: While `req_valid`=1 and `req_ready`=0, the request's address, index and flag stay unchanged. The sequencer advances only on an accepted request.
- R10: An all-zero mask issues no request. It produces `done` and `err` together, one cycle after the command is accepted, and no write-back.
- R11: A command presented while the sequencer is busy (`cmd_ready`=0) is ignored and does not disturb the requests of the operation in flight.
- R12: `done` is high for exactly one cycle, in the cycle after the last request is accepted. `cmd_ready` returns to 1 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle, command accepted when valid |
| cmd_mask | input | NREG | Register selection, bit i selects register i |
| cmd_pre | input | 1 | 1: step before each access, 0: step after |
| cmd_up | input | 1 | 1: addresses ascend from base, 0: descend |
| cmd_wback | input | 1 | 1: report an updated base on completion |
| cmd_load | input | 1 | 1: load (memory read), 0: store |
| cmd_base | input | AW | Base address |
| req_valid | output | 1 | Memory request present |
| req_ready | input | 1 | Memory request accepted |
| req_addr | output | AW | Word address of the request |
| req_idx | output | IW | Register index of the request |
| req_load | output | 1 | 1: read, 0: write |
| wb_valid | output | 1 | Updated base valid (with done) |
| wb_addr | output | AW | Updated base value |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Empty-mask error, with done |

## Verification
The bench builds the block with its defaults: a 16-bit mask and 32-bit addresses. A full sixteen-register list is therefore reachable, which gives the largest span of 64 bytes. It also means a descending transfer from a base of 8 must wrap below zero, so modulo address arithmetic is exercised. Directed runs cover every pair of step direction and step timing. Other runs use sparse, single-bit and full masks, an empty mask, periodic back-pressure on the request handshake, and a conflicting command held during a transfer.

// File: rtl/blk_xfer_pkg.sv
package blk_xfer_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_FIN  = 2'd2
  } seq_state_t;

  typedef struct packed {
    logic pre;
    logic up;
    logic wback;
    logic load;
  } xfer_mode_t;

endpackage

// File: rtl/blk_xfer_plan.sv
// Computes the count of selected registers, the first access address and
// the final base value from the command fields.
module blk_xfer_plan
  import blk_xfer_pkg::*;
#(
  parameter int NREG = 16,
  parameter int AW   = 32,
  localparam int CW  = $clog2(NREG + 1)
) (
  input  logic [NREG-1:0] mask,
  input  xfer_mode_t      mode,
  input  logic [AW-1:0]   base,
  output logic [CW-1:0]   cnt,
  output logic [AW-1:0]   first_addr,
  output logic [AW-1:0]   final_addr,
  output logic            empty
);

  function automatic logic [CW-1:0] count_bits(input logic [NREG-1:0] m);
    logic [CW-1:0] c;
    c = '0;
    for (int i = 0; i < NREG; i++) c = c + CW'(m[i]);
    return c;
  endfunction

  function automatic logic [AW-1:0] start_of(input logic [AW-1:0] b,
                                             input logic [AW-1:0] span,
                                             input logic up, input logic pre);
    logic [AW-1:0] s;
    case ({up, pre})
      2'b10:   s = b;
      2'b11:   s = b + AW'(4);
      2'b00:   s = b - span + AW'(4);
      default: s = b - span;
    endcase
    return s;
  endfunction

  logic [AW-1:0] span;

  always_comb begin
    cnt        = count_bits(mask);
    span       = AW'(cnt) << 2;
    empty      = (cnt == '0);
    first_addr = start_of(base, span, mode.up, mode.pre);
    final_addr = mode.up ? (base + span) : (base - span);
  end

endmodule

// File: rtl/blk_xfer_pick.sv
// Finds the lowest remaining register and whether it is the last one.
module blk_xfer_pick #(
  parameter int NREG = 16,
  localparam int IW  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic [NREG-1:0] rem,
  output logic [IW-1:0]   idx,
  output logic [NREG-1:0] rest,
  output logic            last
);

  always_comb begin
    idx = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (rem[i]) idx = IW'(i);
    end
    rest = rem & (rem - NREG'(1));
    last = (rem != '0) && (rest == '0);
  end

endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq
  import blk_xfer_pkg::*;
#(
  parameter int NREG = 16,
  parameter int AW   = 32,
  localparam int IW  = (NREG > 1) ? $clog2(NREG) : 1,
  localparam int CW  = $clog2(NREG + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic [NREG-1:0] cmd_mask,
  input  logic            cmd_pre,
  input  logic            cmd_up,
  input  logic            cmd_wback,
  input  logic            cmd_load,
  input  logic [AW-1:0]   cmd_base,
  output logic            req_valid,
  input  logic            req_ready,
  output logic [AW-1:0]   req_addr,
  output logic [IW-1:0]   req_idx,
  output logic            req_load,
  output logic            wb_valid,
  output logic [AW-1:0]   wb_addr,
  output logic            done,
  output logic            err
);

  seq_state_t      state_q;
  logic [NREG-1:0] rem_q;
  logic [AW-1:0]   addr_q;
  logic [AW-1:0]   final_q;
  logic            load_q;
  logic            wback_q;
  logic            err_q;

  xfer_mode_t      mode;
  logic [CW-1:0]   plan_cnt;
  logic [AW-1:0]   plan_first;
  logic [AW-1:0]   plan_final;
  logic            plan_empty;
  logic [NREG-1:0] rem_next;
  logic            last_beat;
  logic            cmd_fire;
  logic            beat_fire;

  assign mode = '{pre: cmd_pre, up: cmd_up, wback: cmd_wback, load: cmd_load};

  blk_xfer_plan #(.NREG(NREG), .AW(AW)) plan_i (
    .mask       (cmd_mask),
    .mode       (mode),
    .base       (cmd_base),
    .cnt        (plan_cnt),
    .first_addr (plan_first),
    .final_addr (plan_final),
    .empty      (plan_empty)
  );

  blk_xfer_pick #(.NREG(NREG)) pick_i (
    .rem  (rem_q),
    .idx  (req_idx),
    .rest (rem_next),
    .last (last_beat)
  );

  assign cmd_ready = (state_q == ST_IDLE);
  assign req_valid = (state_q == ST_BUSY);
  assign done      = (state_q == ST_FIN);
  assign cmd_fire  = cmd_valid && cmd_ready;
  assign beat_fire = req_valid && req_ready;
  assign req_addr  = addr_q;
  assign req_load  = load_q;
  assign err       = done && err_q;
  assign wb_valid  = done && wback_q;
  assign wb_addr   = final_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rem_q   <= '0;
      addr_q  <= '0;
      final_q <= '0;
      load_q  <= 1'b0;
      wback_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (cmd_fire) begin
            rem_q   <= cmd_mask;
            addr_q  <= plan_first;
            final_q <= plan_final;
            load_q  <= cmd_load;
            wback_q <= cmd_wback && !plan_empty;
            err_q   <= plan_empty;
            state_q <= plan_empty ? ST_FIN : ST_BUSY;
          end
        end
        ST_BUSY: begin
          if (beat_fire) begin
            rem_q  <= rem_next;
            addr_q <= addr_q + AW'(4);
            if (last_beat) state_q <= ST_FIN;
          end
        end
        default: begin
          state_q <= ST_IDLE;
          err_q   <= 1'b0;
          wback_q <= 1'b0;
        end
      endcase
    end
  end

  logic unused_cnt;
  assign unused_cnt = ^plan_cnt;

endmodule

// File: rtl/blk_xfer_seq_chk.sv
module blk_xfer_seq_chk #(
  parameter int NREG = 16,
  parameter int AW   = 32,
  localparam int IW  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_ready,
  input logic          req_valid,
  input logic          req_ready,
  input logic [AW-1:0] req_addr,
  input logic [IW-1:0] req_idx,
  input logic          req_load,
  input logic          wb_valid,
  input logic          done,
  input logic          err,
  input logic          last_beat
);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_idx) && $stable(req_load));

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !last_beat |=> req_valid && (req_addr == $past(req_addr) + AW'(4)) && (req_idx > $past(req_idx)));

  assert_finish_R12: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && last_beat |=> done && !req_valid);

  assert_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && cmd_ready);

  assert_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done && !wb_valid);

  assert_wb_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> done);

  assert_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_valid, cmd_ready, done}));

endmodule

bind blk_xfer_seq blk_xfer_seq_chk #(.NREG(NREG), .AW(AW)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_ready (cmd_ready),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_addr  (req_addr),
  .req_idx   (req_idx),
  .req_load  (req_load),
  .wb_valid  (wb_valid),
  .done      (done),
  .err       (err),
  .last_beat (last_beat)
);

// File: tb/blk_xfer_seq_tb_top.sv
module blk_xfer_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 16;
  localparam int AW   = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [NREG-1:0] cmd_mask = '0;
  logic cmd_pre = 1'b0, cmd_up = 1'b0, cmd_wback = 1'b0, cmd_load = 1'b0;
  logic [AW-1:0] cmd_base = '0;
  logic req_valid;
  logic req_ready = 1'b0;
  logic [AW-1:0] req_addr;
  logic [3:0] req_idx;
  logic req_load;
  logic wb_valid;
  logic [AW-1:0] wb_addr;
  logic done;
  logic err;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  blk_xfer_seq #(.NREG(NREG), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_mask(cmd_mask),
    .cmd_pre(cmd_pre), .cmd_up(cmd_up), .cmd_wback(cmd_wback),
    .cmd_load(cmd_load), .cmd_base(cmd_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_idx(req_idx), .req_load(req_load),
    .wb_valid(wb_valid), .wb_addr(wb_addr), .done(done), .err(err)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  function automatic int nth_bit(input logic [15:0] m, input int k);
    int seen = 0;
    for (int i = 0; i < 16; i++) begin
      if (m[i]) begin
        if (seen == k) return i;
        seen++;
      end
    end
    return -1;
  endfunction

  // Runs one command; stall>0 withholds req_ready every stall-th cycle;
  // poke holds a conflicting command on the inputs while busy.
  task automatic run_op(input logic [15:0] mask, input bit p, input bit u, input bit w,
                        input bit l, input logic [31:0] base, input int stall,
                        input bit poke, input string tag);
    int n = $countones(mask);
    logic [31:0] lo, hi, wbx, exp_a;
    int k = 0;
    int cyc = 0;
    bit rdy;
    if (u) lo = base + (p ? 32'd4 : 32'd0);
    else begin
      hi = p ? base - 32'd4 : base;
      lo = hi - 32'(4 * (n - 1));
    end
    wbx = u ? base + 32'(4 * n) : base - 32'(4 * n);
    @(negedge clk);
    check(cmd_ready == 1'b1, {tag, " R12 ready before cmd"}, 32'(cmd_ready), 32'd1);
    cmd_mask = mask; cmd_pre = p; cmd_up = u; cmd_wback = w; cmd_load = l; cmd_base = base;
    cmd_valid = 1'b1;
    @(negedge clk);
    if (poke) begin
      cmd_mask = 16'hFFFF; cmd_up = ~u; cmd_load = ~l; cmd_base = 32'hDEAD_0000;
    end else cmd_valid = 1'b0;
    while (cyc < 200) begin
      if (req_valid) begin
        exp_a = lo + 32'(4 * k);
        check(k < n && req_addr == exp_a, {tag, " R2 address"}, req_addr, exp_a);
        check(32'(req_idx) == 32'(nth_bit(mask, k)), {tag, " R2 index"}, 32'(req_idx), 32'(nth_bit(mask, k)));
        check(req_load == l, {tag, " R8 direction"}, 32'(req_load), 32'(l));
        rdy = (stall == 0) || (cyc % stall != 0);
        req_ready = rdy;
        if (rdy) k++;
      end else if (done) break;
      @(negedge clk);
      cyc++;
    end
    cmd_valid = 1'b0;
    req_ready = 1'b0;
    check(done == 1'b1, {tag, " R12 done seen"}, 32'(done), 32'd1);
    check(k == n, {tag, " R2 request count"}, 32'(k), 32'(n));
    check(err == (n == 0), {tag, " R10 err"}, 32'(err), 32'(n == 0));
    check(wb_valid == (w && n > 0), {tag, " R7 wb_valid"}, 32'(wb_valid), 32'(w && n > 0));
    if (w && n > 0) check(wb_addr == wbx, {tag, " R7 wb_addr"}, wb_addr, wbx);
    @(negedge clk);
    check(done == 1'b0 && cmd_ready == 1'b1, {tag, " R12 pulse end"}, 32'({done, cmd_ready}), 32'b01);
  endtask

  task automatic t_reset;
    check(cmd_ready && !req_valid && !done && !err && !wb_valid, "R1 reset state",
          32'({cmd_ready, req_valid, done, err, wb_valid}), 32'b10000);
  endtask

  task automatic t_inc_after;  run_op(16'h80F3, 1'b0, 1'b1, 1'b1, 1'b1, 32'h0000_1000, 0, 1'b0, "R3 inc-after pop"); endtask
  task automatic t_inc_before; run_op(16'h0421, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0000_2000, 0, 1'b0, "R4 inc-before"); endtask
  task automatic t_dec_after;  run_op(16'h00F0, 1'b0, 1'b0, 1'b1, 1'b1, 32'h0000_2400, 0, 1'b0, "R5 dec-after"); endtask
  task automatic t_dec_before; run_op(16'h403B, 1'b1, 1'b0, 1'b1, 1'b0, 32'h0000_3000, 3, 1'b0, "R6 R9 push stalled"); endtask
  task automatic t_empty;      run_op(16'h0000, 1'b1, 1'b0, 1'b1, 1'b0, 32'h0000_4000, 0, 1'b0, "R10 empty"); endtask
  task automatic t_busy;       run_op(16'h0006, 1'b0, 1'b1, 1'b0, 1'b1, 32'h0000_5000, 2, 1'b1, "R11 busy ignore"); endtask
  task automatic t_full_wrap;  run_op(16'hFFFF, 1'b1, 1'b0, 1'b1, 1'b0, 32'h0000_0008, 0, 1'b0, "R6 full wrap"); endtask
  task automatic t_single;     run_op(16'h8000, 1'b0, 1'b1, 1'b1, 1'b1, 32'hFFFF_FFF0, 0, 1'b0, "R3 R7 single"); endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_inc_after();
    t_inc_before();
    t_dec_after();
    t_dec_before();
    t_empty();
    t_busy();
    t_full_wrap();
    t_single();
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

endmodule